// File: doc/BRIEF.md
# Closed Caption Line Inserter

This block places a pair of 7-bit caption characters onto one video line. A line-timing generator supplies the current line number, the field id and a running pixel count, one pixel per clock. When insertion is enabled and the line, field and pixel count all equal the programmed targets, the block sends one caption frame as a serial bit stream. The frame is a clock run-in, a start pattern and sixteen data bits. A downstream modulator uses that stream together with a gate that marks the frame window.

Software loads the two characters and sets a ready flag, which sits outside this block. If ready is set when a frame starts, the loaded characters are sent and a one-cycle done strobe follows the frame, so the external logic can clear ready. If ready is clear, the frame still goes out on the target line but carries two null characters, and no strobe is given. The character pair, the ready state and the frame contents are captured when the frame starts, so later writes cannot corrupt a frame that is already being sent.

Top module: `cc_line_inserter`

## Requirements
- R1: A frame starts only when `cfg_enable` is 1, `line_num` equals `cfg_line`, `field_id` equals `cfg_field` and `pix_cnt` equals `cfg_hoffset`. `cc_active` goes high in the clock cycle after the cycle in which that match is presented. This includes an offset of 0.
- R2: No frame is sent, and `cc_done` stays low, when enable is 0, when the field id differs from the selected field, or when the line number differs from the target line.
- R3: `cc_active` stays high for exactly FRAME_BITS*BIT_PIX consecutive cycles, which is (7+3+16)*4 = 104 with the default parameters. Each serial bit is held for BIT_PIX cycles.
- R4: Frame bit 0 is sent first. Bits 0 to RUNIN_BITS-1 form the run-in, which alternates 1,0,1,... and starts with 1. The next three bits are the start pattern 0,0,1.
- R5: The 16 data bits follow in this order: the first character, LSB first, then its odd-parity bit; then the second character, LSB first, then its odd-parity bit. The parity bit makes the count of ones in the 8 bits odd.
- R6: If `cc_ready` is 0 in the start cycle, both characters are sent as 0x00, each with parity bit 1.
- R7: If `cc_ready` was 1 in the start cycle, `cc_done` is high for exactly one cycle, in the cycle right after `cc_active` falls. `cc_done` is never high at any other time.
- R8: Once a frame has started, changes to the characters or to `cc_ready`, and a second pixel match, have no effect on that frame.
- R9: `cc_bit` is 0 whenever `cc_active` is 0. Reset drives `cc_active`, `cc_bit` and `cc_done` to 0 at once, even in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_num | input | LINE_W (10) | Current line number from the timing generator |
| field_id | input | 1 | Current field id |
| pix_cnt | input | PIX_W (12) | Current pixel count within the line |
| cfg_enable | input | 1 | Enables caption insertion |
| cfg_field | input | 1 | Field that carries the caption |
| cfg_hoffset | input | 10 | Pixel count at which the frame starts |
| cfg_line | input | 6 | Target line number |
| cc_char1 | input | 7 | First character, sent first |
| cc_char2 | input | 7 | Second character |
| cc_ready | input | 1 | New character pair has been loaded |
| cc_active | output | 1 | Gate that is high for the whole frame window |
| cc_bit | output | 1 | Serial caption bit for the modulator |
| cc_done | output | 1 | One-cycle strobe after a loaded pair is sent; used to clear ready |

## Verification
The match is registered once, so `cc_active` and the first run-in bit appear one cycle after the matching pixel count is driven. Frame bit k is then valid from cycle 1+k*BIT_PIX to cycle BIT_PIX*(k+1) after the match. The done strobe is due exactly 1+FRAME_BITS*BIT_PIX cycles after the match. The bench drives one pixel per falling edge and records the outputs at each falling edge before it drives the next pixel, so each recorded sample reflects the previous rising edge. It reads each frame bit in the middle of its BIT_PIX window and compares the gate start, the gate length and the strobe position against these offsets.

// File: rtl/cc_ins_pkg.sv
package cc_ins_pkg;

    localparam int CHAR_W    = 7;
    localparam int START_LEN = 3;
    localparam int DATA_LEN  = 2 * (CHAR_W + 1);

    typedef enum logic [0:0] {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } cc_phase_e;

    // parity bit that makes the 8-bit group hold an odd number of ones
    function automatic logic odd_parity(input logic [CHAR_W-1:0] ch);
        return ~(^ch);
    endfunction

endpackage

// File: rtl/cc_trigger.sv
module cc_trigger #(
    parameter int LINE_W  = 10,
    parameter int PIX_W   = 12,
    parameter int HOFF_W  = 10,
    parameter int TLINE_W = 6
) (
    input  logic              enable,
    input  logic [LINE_W-1:0] line_num,
    input  logic              field_id,
    input  logic [PIX_W-1:0]  pix_cnt,
    input  logic              tgt_field,
    input  logic [HOFF_W-1:0] tgt_hoff,
    input  logic [TLINE_W-1:0] tgt_line,
    output logic              hit
);

    logic line_eq;
    logic pix_eq;
    logic fld_eq;

    always_comb begin
        line_eq = (line_num == LINE_W'(tgt_line));
        pix_eq  = (pix_cnt == PIX_W'(tgt_hoff));
        fld_eq  = (field_id == tgt_field);
        hit     = enable & line_eq & pix_eq & fld_eq;
    end

endmodule

// File: rtl/cc_frame_build.sv
module cc_frame_build
    import cc_ins_pkg::*;
#(
    parameter int RUNIN_BITS = 7,
    localparam int FRAME_BITS = RUNIN_BITS + START_LEN + DATA_LEN
) (
    input  logic [CHAR_W-1:0]     char_a,
    input  logic [CHAR_W-1:0]     char_b,
    input  logic                  use_loaded,
    output logic [FRAME_BITS-1:0] frame
);

    logic [RUNIN_BITS-1:0] runin_w;
    logic [START_LEN-1:0]  start_w;
    logic [DATA_LEN-1:0]   data_w;
    logic [CHAR_W-1:0]     a_sel;
    logic [CHAR_W-1:0]     b_sel;

    for (genvar gi = 0; gi < RUNIN_BITS; gi++) begin : g_runin
        assign runin_w[gi] = ((gi % 2) == 0);
    end

    // sent order: 0, 0, 1
    assign start_w = 3'b100;

    always_comb begin
        a_sel  = use_loaded ? char_a : '0;
        b_sel  = use_loaded ? char_b : '0;
        data_w = {odd_parity(b_sel), b_sel, odd_parity(a_sel), a_sel};
        frame  = {data_w, start_w, runin_w};
    end

endmodule

// File: rtl/cc_serializer.sv
module cc_serializer
    import cc_ins_pkg::*;
#(
    parameter int FRAME_BITS = 26,
    parameter int BIT_PIX    = 4,
    localparam int IDX_W = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1,
    localparam int SUB_W = (BIT_PIX > 1) ? $clog2(BIT_PIX) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  hit,
    input  logic                  loaded,
    input  logic [FRAME_BITS-1:0] frame_in,
    output logic                  active,
    output logic                  ser_bit,
    output logic                  done
);

    typedef struct packed {
        cc_phase_e             ph;
        logic [FRAME_BITS-1:0] frame;
        logic [IDX_W-1:0]      idx;
        logic [SUB_W-1:0]      sub;
        logic                  was_loaded;
        logic                  done;
    } ser_state_t;

    localparam ser_state_t RST_STATE = '{
        ph:         PH_IDLE,
        frame:      '0,
        idx:        '0,
        sub:        '0,
        was_loaded: 1'b0,
        done:       1'b0
    };

    ser_state_t st_d;
    ser_state_t st_q;

    logic last_sub;
    logic last_bit;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        last_sub  = (st_q.sub == SUB_W'(BIT_PIX - 1));
        last_bit  = (st_q.idx == IDX_W'(FRAME_BITS - 1));
        unique case (st_q.ph)
            PH_IDLE: begin
                if (hit) begin
                    st_d.ph         = PH_SEND;
                    st_d.frame      = frame_in;
                    st_d.idx        = '0;
                    st_d.sub        = '0;
                    st_d.was_loaded = loaded;
                end
            end
            PH_SEND: begin
                if (last_sub) begin
                    st_d.sub = '0;
                    if (last_bit) begin
                        st_d.ph   = PH_IDLE;
                        st_d.done = st_q.was_loaded;
                    end else begin
                        st_d.idx = st_q.idx + 1'b1;
                    end
                end else begin
                    st_d.sub = st_q.sub + 1'b1;
                end
            end
            default: st_d = RST_STATE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = (st_q.ph == PH_SEND);
    assign ser_bit = active & st_q.frame[st_q.idx];
    assign done    = st_q.done;

endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter
    import cc_ins_pkg::*;
#(
    parameter int LINE_W     = 10,
    parameter int PIX_W      = 12,
    parameter int HOFF_W     = 10,
    parameter int TLINE_W    = 6,
    parameter int RUNIN_BITS = 7,
    parameter int BIT_PIX    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINE_W-1:0]  line_num,
    input  logic               field_id,
    input  logic [PIX_W-1:0]   pix_cnt,
    input  logic               cfg_enable,
    input  logic               cfg_field,
    input  logic [HOFF_W-1:0]  cfg_hoffset,
    input  logic [TLINE_W-1:0] cfg_line,
    input  logic [CHAR_W-1:0]  cc_char1,
    input  logic [CHAR_W-1:0]  cc_char2,
    input  logic               cc_ready,
    output logic               cc_active,
    output logic               cc_bit,
    output logic               cc_done
);

    localparam int FRAME_BITS = RUNIN_BITS + START_LEN + DATA_LEN;

    logic                  hit_w;
    logic [FRAME_BITS-1:0] frame_w;

    cc_trigger #(
        .LINE_W (LINE_W),
        .PIX_W  (PIX_W),
        .HOFF_W (HOFF_W),
        .TLINE_W(TLINE_W)
    ) trig_i (
        .enable   (cfg_enable),
        .line_num (line_num),
        .field_id (field_id),
        .pix_cnt  (pix_cnt),
        .tgt_field(cfg_field),
        .tgt_hoff (cfg_hoffset),
        .tgt_line (cfg_line),
        .hit      (hit_w)
    );

    cc_frame_build #(
        .RUNIN_BITS(RUNIN_BITS)
    ) build_i (
        .char_a    (cc_char1),
        .char_b    (cc_char2),
        .use_loaded(cc_ready),
        .frame     (frame_w)
    );

    cc_serializer #(
        .FRAME_BITS(FRAME_BITS),
        .BIT_PIX   (BIT_PIX)
    ) ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (hit_w),
        .loaded  (cc_ready),
        .frame_in(frame_w),
        .active  (cc_active),
        .ser_bit (cc_bit),
        .done    (cc_done)
    );

endmodule

// File: rtl/cc_line_inserter_chk.sv
module cc_line_inserter_chk #(
    parameter int LINE_W     = 10,
    parameter int PIX_W      = 12,
    parameter int HOFF_W     = 10,
    parameter int TLINE_W    = 6,
    parameter int FRAME_BITS = 26,
    parameter int BIT_PIX    = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LINE_W-1:0]  line_num,
    input logic               field_id,
    input logic [PIX_W-1:0]   pix_cnt,
    input logic               cfg_enable,
    input logic               cfg_field,
    input logic [HOFF_W-1:0]  cfg_hoffset,
    input logic [TLINE_W-1:0] cfg_line,
    input logic               cc_active,
    input logic               cc_bit,
    input logic               cc_done
);

    localparam int WIN = FRAME_BITS * BIT_PIX;
    localparam int RL_W = $clog2(WIN + 2);

    logic [RL_W-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (cc_active) begin
            if (run_len <= RL_W'(WIN)) run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R1
    start_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_active) |-> $past(cfg_enable && (field_id == cfg_field)
            && (pix_cnt == PIX_W'(cfg_hoffset)) && (line_num == LINE_W'(cfg_line))));

    // R2
    disabled_no_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cc_active && !cfg_enable) |=> !cc_active);

    // R3
    window_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_active |-> (run_len < RL_W'(WIN)));

    // R3
    window_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cc_active) |-> (run_len == RL_W'(WIN)));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_done |=> !cc_done);

    // R7
    done_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_done |-> (!cc_active && $past(cc_active)));

    // R9
    idle_bit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_active |-> !cc_bit);

endmodule

bind cc_line_inserter cc_line_inserter_chk #(
    .LINE_W    (LINE_W),
    .PIX_W     (PIX_W),
    .HOFF_W    (HOFF_W),
    .TLINE_W   (TLINE_W),
    .FRAME_BITS(FRAME_BITS),
    .BIT_PIX   (BIT_PIX)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_num   (line_num),
    .field_id   (field_id),
    .pix_cnt    (pix_cnt),
    .cfg_enable (cfg_enable),
    .cfg_field  (cfg_field),
    .cfg_hoffset(cfg_hoffset),
    .cfg_line   (cfg_line),
    .cc_active  (cc_active),
    .cc_bit     (cc_bit),
    .cc_done    (cc_done)
);

// File: tb/cc_line_inserter_tb_top.sv
module cc_line_inserter_tb_top;

    localparam int RUNIN  = 7;
    localparam int BP     = 4;
    localparam int FBITS  = RUNIN + 3 + 16;
    localparam int WIN    = FBITS * BP;
    localparam int LPIX   = 160;
    localparam int TLINE  = 21;

    typedef struct packed {
        logic       en;
        logic       fsel;
        logic       fid;
        logic       on_line;
        logic [9:0] hoff;
        logic [6:0] c1;
        logic [6:0] c2;
        logic       rdy;
        logic       glitch;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b0, 1'b0, 1'b1, 10'd20, 7'h41, 7'h42, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 10'd0,  7'h7F, 7'h00, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 10'd33, 7'h55, 7'h2A, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 10'd20, 7'h41, 7'h42, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b1, 1'b1, 10'd20, 7'h41, 7'h42, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 10'd7,  7'h13, 7'h6C, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b0, 10'd20, 7'h41, 7'h42, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b0, 1'b1, 10'd25, 7'h21, 7'h3E, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  line_num = '0;
    logic        field_id = 1'b0;
    logic [11:0] pix_cnt = '0;
    logic        cfg_enable = 1'b0;
    logic        cfg_field = 1'b0;
    logic [9:0]  cfg_hoffset = '0;
    logic [5:0]  cfg_line = 6'(TLINE);
    logic [6:0]  cc_char1 = '0;
    logic [6:0]  cc_char2 = '0;
    logic        cc_ready = 1'b0;
    logic        cc_active;
    logic        cc_bit;
    logic        cc_done;

    int n_chk = 0;
    int n_bad = 0;

    logic s_act  [LPIX];
    logic s_bit  [LPIX];
    logic s_done [LPIX];

    always #5 clk = ~clk;

    cc_line_inserter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_num   (line_num),
        .field_id   (field_id),
        .pix_cnt    (pix_cnt),
        .cfg_enable (cfg_enable),
        .cfg_field  (cfg_field),
        .cfg_hoffset(cfg_hoffset),
        .cfg_line   (cfg_line),
        .cc_char1   (cc_char1),
        .cc_char2   (cc_char2),
        .cc_ready   (cc_ready),
        .cc_active  (cc_active),
        .cc_bit     (cc_bit),
        .cc_done    (cc_done)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic exp_bit(input int k, input logic [6:0] a,
                                     input logic [6:0] b, input logic r);
        logic [6:0]  x;
        logic [6:0]  y;
        logic [15:0] pl;
        x  = r ? a : 7'h00;
        y  = r ? b : 7'h00;
        pl = {~(^y), y, ~(^x), x};
        if (k < RUNIN) return (k % 2) == 0;
        if (k < RUNIN + 2) return 1'b0;
        if (k == RUNIN + 2) return 1'b1;
        return pl[k - RUNIN - 3];
    endfunction

    task automatic idle_gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_num = 10'd50;
            pix_cnt  = '0;
        end
    endtask

    // one line sweep, one pixel per clock; sample then drive at each falling edge
    task automatic run_line(input logic [9:0] ln, input logic fid, input logic glitch,
                            input int h);
        for (int p = 0; p < LPIX; p++) begin
            @(negedge clk);
            s_act[p]  = cc_active;
            s_bit[p]  = cc_bit;
            s_done[p] = cc_done;
            if (cc_done) cc_ready = 1'b0;
            line_num = ln;
            field_id = fid;
            pix_cnt  = 12'(p);
            if (glitch && p == h + 6) begin
                cc_char1 = ~cc_char1;
                cc_char2 = ~cc_char2;
                cc_ready = ~cc_ready;
            end
            if (glitch && p == h + 10) pix_cnt = 12'(h);
        end
    endtask

    task automatic judge(input logic want, input logic want_done, input int h,
                         input logic [6:0] a, input logic [6:0] b, input logic r,
                         input string tag);
        int n_act;
        int n_done;
        n_act = 0;
        n_done = 0;
        for (int p = 0; p < LPIX; p++) begin
            n_act  += int'(s_act[p]);
            n_done += int'(s_done[p]);
        end
        if (!want) begin
            check(n_act == 0, {"R2 no gate ", tag}, n_act, 0);
            check(n_done == 0, {"R2 no done ", tag}, n_done, 0);
        end else begin
            check(s_act[h] == 1'b0 && s_act[h+1] == 1'b1, {"R1 gate start ", tag},
                  int'(s_act[h+1]), 1);
            check(n_act == WIN && s_act[h+WIN] == 1'b1 && s_act[h+WIN+1] == 1'b0,
                  {"R3 gate length ", tag}, n_act, WIN);
            for (int k = 0; k < FBITS; k++) begin
                logic e;
                logic g;
                e = exp_bit(k, a, b, r);
                g = s_bit[h + 1 + k*BP + BP/2];
                if (k < RUNIN + 3)
                    check(g == e, {"R4 preamble bit ", tag}, int'(g), int'(e));
                else if (r)
                    check(g == e, {"R5 data bit ", tag}, int'(g), int'(e));
                else
                    check(g == e, {"R6 null bit ", tag}, int'(g), int'(e));
            end
            check(s_done[h+1+WIN] == want_done && n_done == int'(want_done),
                  {"R7 done strobe ", tag}, n_done, int'(want_done));
        end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        check(!cc_active && !cc_bit && !cc_done, "R9 reset outputs",
              int'({cc_active, cc_bit, cc_done}), 0);
        rst_n = 1'b1;
        idle_gap(3);

        for (int v = 0; v < NVEC; v++) begin
            vec_t t;
            logic want;
            string tag;
            t = VECS[v];
            tag = $sformatf("vec%0d", v);
            cfg_enable  = t.en;
            cfg_field   = t.fsel;
            cfg_hoffset = t.hoff;
            cc_char1    = t.c1;
            cc_char2    = t.c2;
            cc_ready    = t.rdy;
            run_line(t.on_line ? 10'(TLINE) : 10'(TLINE + 1), t.fid, t.glitch, int'(t.hoff));
            want = t.en && t.on_line && (t.fsel == t.fid);
            // vec7 carries R8: mid-frame writes and a second match must not alter the result
            judge(want, want && t.rdy, int'(t.hoff), t.c1, t.c2, t.rdy, tag);
            idle_gap(3);
        end

        // R8 ready cleared by the done strobe in the bench model after a loaded frame
        check(cc_ready == 1'b0, "R8 ready cleared after frame", int'(cc_ready), 0);

        // R9 reset in the middle of a frame
        cfg_enable  = 1'b1;
        cfg_field   = 1'b0;
        cfg_hoffset = 10'd5;
        cc_char1    = 7'h7F;
        cc_char2    = 7'h7F;
        cc_ready    = 1'b1;
        for (int p = 0; p < 40; p++) begin
            @(negedge clk);
            line_num = 10'(TLINE);
            field_id = 1'b0;
            pix_cnt  = 12'(p);
        end
        check(cc_active == 1'b1, "R9 frame running before reset", int'(cc_active), 1);
        rst_n = 1'b0;
        #1;
        check(!cc_active && !cc_bit && !cc_done, "R9 reset mid-frame",
              int'({cc_active, cc_bit, cc_done}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle_gap(WIN + 4);
        check(!cc_done && !cc_active, "R9 no late done after reset",
              int'({cc_active, cc_done}), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule